// File: doc/BRIEF.md
# SONET Receive Frame Timing Marker

This block sits on a receive SONET word stream at the STS-48 rate: one 32-bit word per 77.76 MHz clock, byte-aligned within the word. It hunts for the framing pattern. That pattern is a run of words that hold only the first framing byte (0xF6), followed by a word that holds only the second framing byte (0x28). From the spot where the pattern is found, it derives the phase of the 9720-word frame.

The block confirms that phase over later frames before it declares lock. From then on it coasts on its own row and column counters. Each output word carries two markers:

- a frame pulse on the first word of every frame;
- a payload flag that is low in the 36 overhead words and high in the 1044 payload words of each row.

Lost framing is tolerated for up to three frames in a row. A fourth consecutive miss drops lock, and the block hunts again at whatever new phase the stream shows.

Top module: `sonet_rx_framer`

## Requirements
- R1: A frame boundary is seen only when a word equal to 32'hF6F6F6F6 is followed directly by a word equal to 32'h28282828. A word that holds the second framing byte in only some of its bytes (for example 32'h28282800) is not a boundary. The first word of the frame lies 12 words before the first 32'h28282828 word, so the boundary word is frame word 12.
- R2: After the first sighting, `locked_o` goes high once the boundary is also found at the expected frame word 12 in the next two frames. It is high at the first falling clock edge after the clock edge that takes in that word.
- R3: While `locked_o` is low when a word enters, the `frame_pulse_o` and `payload_o` that go out with that word are both low.
- R4: For a word that entered while locked, `frame_pulse_o` is high for exactly one cycle, with the output word that is frame word 0. A frame therefore carries one pulse every 9720 words.
- R5: Frame word p has row p/1080 (rows 0 to 8) and column p%1080. For a word that entered while locked, `payload_o` is low for columns 0 to 35 and high for columns 36 to 1079, in every row.
- R6: `data_o` equals `data_i` delayed by one clock. The two markers refer to the word shown on `data_o` in the same cycle.
- R7: While locked, one to three consecutive frames that lack the boundary at frame word 12 leave `locked_o` high, and the markers keep their phase. A frame that shows the boundary again clears the run of misses.
- R8: The fourth consecutive frame without the boundary at frame word 12 drops `locked_o`. It is low at the first falling edge after that word is taken in, and the markers stay low afterwards.
- R9: While locked, a boundary pattern at any other frame position does not move the marker phase.
- R10: After lock is lost, the block locks again, by the rule of R2, to a stream whose frames start at a new phase, and it marks frames at that new phase.
- R11: Reset (`rst_ni` low) clears lock, both markers and `data_o`, whatever state the block was in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 32 | Receive word, byte-aligned |
| data_o | output | 32 | Receive word, one cycle later |
| frame_pulse_o | output | 1 | High with frame word 0 while locked |
| payload_o | output | 1 | High for payload columns while locked |
| locked_o | output | 1 | Frame phase confirmed |

## Verification
The stream is fed in several forms, and each one separates a different part of the lock rule:

- Clean frames show when lock is gained, and that no marker appears before it.
- Frames whose first second-byte word is only partly correct separate a tolerated miss from a loss of lock. One frame in that run also carries a stray boundary deep in the payload, which shows that a locked phase does not follow a false pattern.
- A good frame between two runs of misses shows that the miss count is cleared.
- A gap of filler words before fresh frames moves the phase. This shows that the hunt picks up the new alignment, rather than keeping the old one.
- Every output word is compared with the row and column it should carry, so an error of one word in the pulse or in the payload edge is caught.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam logic [7:0] FRM_BYTE_1 = 8'hF6;
  localparam logic [7:0] FRM_BYTE_2 = 8'h28;

  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_PRESYNC = 2'd1,
    ST_SYNC    = 2'd2
  } lock_state_e;
endpackage

// File: rtl/sfr_detect.sv
module sfr_detect #(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] data_i,
  output logic              hit_o
);
  import sfr_pkg::*;
  localparam int NB = WORD_W / 8;

  logic [WORD_W-1:0] prev_q;
  logic [NB-1:0]     b1_match, b2_match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= data_i;
  end

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign b1_match[b] = (prev_q[b*8 +: 8] == FRM_BYTE_1);
    assign b2_match[b] = (data_i[b*8 +: 8] == FRM_BYTE_2);
  end

  // only whole-word matches count (R1)
  assign hit_o = (&b1_match) & (&b2_match);
endmodule

// File: rtl/sfr_pos_cnt.sv
module sfr_pos_cnt #(
  parameter int OH_WORDS = 36,
  parameter int PL_WORDS = 1044,
  parameter int ROWS     = 9,
  parameter int A1_WORDS = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic at_start_o,
  output logic at_check_o,
  output logic in_payload_o
);
  localparam int ROW_LEN = OH_WORDS + PL_WORDS;
  localparam int COL_W   = $clog2(ROW_LEN);
  localparam int ROW_W   = $clog2(ROWS);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(ROW_LEN - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
  localparam logic [COL_W-1:0] COL_LOAD = COL_W'(A1_WORDS + 1);
  localparam logic [COL_W-1:0] COL_CHK  = COL_W'(A1_WORDS);
  localparam logic [COL_W-1:0] COL_PL   = COL_W'(OH_WORDS);

  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      row_q <= '0;
    end else if (load_i) begin
      // boundary word is column A1_WORDS; next word is one further
      col_q <= COL_LOAD;
      row_q <= '0;
    end else if (col_q == COL_LAST) begin
      col_q <= '0;
      row_q <= (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
    end else begin
      col_q <= col_q + 1'b1;
    end
  end

  assign at_start_o   = (row_q == '0) && (col_q == '0);
  assign at_check_o   = (row_q == '0) && (col_q == COL_CHK);
  assign in_payload_o = (col_q >= COL_PL);

  assert_load_phase_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (col_q == COL_LOAD) && (row_q == '0));
  assert_pos_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_q <= COL_LAST) && (row_q <= ROW_LAST));
endmodule

// File: rtl/sfr_lock.sv
module sfr_lock #(
  parameter int CONFIRM_FRAMES = 2,
  parameter int MISS_LIMIT     = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic expect_i,
  output logic load_o,
  output logic locked_o
);
  import sfr_pkg::*;
  localparam int HW = $clog2(CONFIRM_FRAMES + 1);
  localparam int MW = $clog2(MISS_LIMIT + 1);
  localparam logic [HW-1:0] HIT_LAST  = HW'(CONFIRM_FRAMES - 1);
  localparam logic [MW-1:0] MISS_LAST = MW'(MISS_LIMIT - 1);

  lock_state_e     state_q, state_d;
  logic [HW-1:0]   hits_q, hits_d;
  logic [MW-1:0]   miss_q, miss_d;

  always_comb begin
    state_d = state_q;
    hits_d  = hits_q;
    miss_d  = miss_q;
    unique case (state_q)
      ST_HUNT: begin
        if (hit_i) begin
          state_d = ST_PRESYNC;
          hits_d  = '0;
        end
      end
      ST_PRESYNC: begin
        if (expect_i) begin
          if (!hit_i) begin
            state_d = ST_HUNT;
          end else if (hits_q == HIT_LAST) begin
            state_d = ST_SYNC;
            miss_d  = '0;
          end else begin
            hits_d = hits_q + 1'b1;
          end
        end
      end
      ST_SYNC: begin
        if (expect_i) begin
          if (hit_i)                  miss_d  = '0;
          else if (miss_q == MISS_LAST) state_d = ST_HUNT;
          else                        miss_d  = miss_q + 1'b1;
        end
      end
      default: state_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT;
      hits_q  <= '0;
      miss_q  <= '0;
    end else begin
      state_q <= state_d;
      hits_q  <= hits_d;
      miss_q  <= miss_d;
    end
  end

  // phase is reloaded only while hunting (R9)
  assign load_o   = (state_q == ST_HUNT) && hit_i;
  assign locked_o = (state_q == ST_SYNC);

  assert_lock_on_hit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(hit_i && expect_i));
  assert_drop_on_miss_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_o) |-> $past(expect_i && !hit_i));
  assert_miss_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_q < MW'(MISS_LIMIT));
endmodule

// File: rtl/sonet_rx_framer.sv
module sonet_rx_framer #(
  parameter int WORD_W         = 32,
  parameter int OH_WORDS       = 36,
  parameter int PL_WORDS       = 1044,
  parameter int ROWS           = 9,
  parameter int A1_WORDS       = 12,
  parameter int CONFIRM_FRAMES = 2,
  parameter int MISS_LIMIT     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] data_o,
  output logic              frame_pulse_o,
  output logic              payload_o,
  output logic              locked_o
);
  logic hit, load, locked, at_start, at_check, in_payload;

  sfr_detect #(.WORD_W(WORD_W)) u_detect (
    .clk_i (clk_i), .rst_ni(rst_ni), .data_i(data_i), .hit_o(hit)
  );

  sfr_pos_cnt #(
    .OH_WORDS(OH_WORDS), .PL_WORDS(PL_WORDS), .ROWS(ROWS), .A1_WORDS(A1_WORDS)
  ) u_pos (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load),
    .at_start_o(at_start), .at_check_o(at_check), .in_payload_o(in_payload)
  );

  sfr_lock #(.CONFIRM_FRAMES(CONFIRM_FRAMES), .MISS_LIMIT(MISS_LIMIT)) u_lock (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit), .expect_i(at_check),
    .load_o(load), .locked_o(locked)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o        <= '0;
      frame_pulse_o <= 1'b0;
      payload_o     <= 1'b0;
    end else begin
      data_o        <= data_i;
      frame_pulse_o <= locked && at_start;
      payload_o     <= locked && in_payload;
    end
  end

  assign locked_o = locked;

  assert_pulse_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_pulse_o |=> !frame_pulse_o);
  assert_pulse_in_overhead_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_pulse_o |-> !payload_o);
  assert_marks_need_lock_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_pulse_o || payload_o) |-> $past(locked));
endmodule

// File: tb/sonet_rx_framer_bench.sv
`timescale 1ns/1ps
module sonet_rx_framer_bench;
  localparam int ROW_LEN = 1080;
  localparam int FRAME   = 9720;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] data_i = '0;
  logic [31:0] data_o;
  logic        frame_pulse_o, payload_o, locked_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [31:0] prev_w;
  int          prev_pos;
  bit          prev_mark, have_prev;
  int          mism, fp_seen, pl_seen;
  string       bad_txt;

  always #10 clk = ~clk;

  sonet_rx_framer u_sonet_rx_framer (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data_i), .data_o(data_o),
    .frame_pulse_o(frame_pulse_o), .payload_o(payload_o), .locked_o(locked_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // sample output for previous word, then drive the next one
  task automatic push(input logic [31:0] w, input int pos, input bit mark);
    bit efp, epl;
    @(negedge clk);
    if (have_prev) begin
      efp = prev_mark && (prev_pos == 0);
      epl = prev_mark && (prev_pos >= 0) && ((prev_pos % ROW_LEN) >= 36);
      if (data_o !== prev_w || frame_pulse_o !== efp || payload_o !== epl) begin
        if (mism == 0)
          bad_txt = $sformatf("pos %0d data %h/%h fp %b/%b pl %b/%b", prev_pos,
                              data_o, prev_w, frame_pulse_o, efp, payload_o, epl);
        mism++;
      end
      if (frame_pulse_o === 1'b1) fp_seen++;
      if (payload_o === 1'b1) pl_seen++;
    end
    data_i    = w;
    prev_w    = w;
    prev_pos  = pos;
    prev_mark = mark;
    have_prev = 1'b1;
  endtask

  function automatic logic [31:0] fill_word(input int pos);
    return 32'hA500_0000 | 32'(pos);
  endfunction

  // mode: 0 good, 1 partial second-byte word, 2 partial + stray boundary at 500
  task automatic send_frame(input int mode, input bit mark_lo, input bit mark_hi,
                            output bit lk_after);
    logic [31:0] w;
    for (int p = 0; p < FRAME; p++) begin
      if (p < 12)                          w = 32'hF6F6_F6F6;
      else if (p == 12 && mode != 0)       w = 32'h2828_2800;
      else if (p < 24)                     w = 32'h2828_2828;
      else if (mode == 2 && p == 500)      w = 32'hF6F6_F6F6;
      else if (mode == 2 && p == 501)      w = 32'h2828_2828;
      else                                 w = fill_word(p);
      push(w, p, (p <= 12) ? mark_lo : mark_hi);
      if (p == 13) lk_after = locked_o;
    end
  endtask

  task automatic clear_stats();
    mism = 0; fp_seen = 0; pl_seen = 0; bad_txt = "";
  endtask

  task automatic report_marks(input string req, input int exp_fp);
    check(mism == 0, req, {"marker/data mismatch ", bad_txt}, mism, 0);
    check(fp_seen == exp_fp, req, "frame pulse count", fp_seen, exp_fp);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    check(locked_o == 1'b0 && frame_pulse_o == 1'b0 && payload_o == 1'b0 && data_o == '0,
          "R11", "outputs in reset", {locked_o, frame_pulse_o, payload_o}, 0);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic t_acquire();
    bit lk0, lk1, lk2;
    clear_stats();
    send_frame(0, 0, 0, lk0);
    send_frame(0, 0, 0, lk1);
    check(lk0 == 0 && lk1 == 0, "R2", "lock before two confirmations", {lk0, lk1}, 0);
    check(fp_seen == 0 && pl_seen == 0, "R3", "markers before lock", fp_seen + pl_seen, 0);
    send_frame(0, 0, 1, lk2);
    check(lk2 == 1, "R2", "lock after second confirmation", lk2, 1);
    check(fp_seen == 0, "R3", "no pulse in locking frame", fp_seen, 0);
    clear_stats();
    send_frame(0, 1, 1, lk2);
    report_marks("R4 R5 R6 R1", 1);
  endtask

  task automatic t_flywheel();
    bit lk;
    int held = 0;
    clear_stats();
    send_frame(1, 1, 1, lk); held += lk;
    send_frame(2, 1, 1, lk); held += lk;
    send_frame(1, 1, 1, lk); held += lk;
    check(held == 3, "R7", "lock held over three misses", held, 3);
    send_frame(0, 1, 1, lk);
    check(lk == 1, "R7", "lock after recovery frame", lk, 1);
    report_marks("R7 R9", 4);
  endtask

  task automatic t_loss();
    bit lk;
    int held = 0;
    clear_stats();
    send_frame(1, 1, 1, lk); held += lk;
    send_frame(1, 1, 1, lk); held += lk;
    send_frame(1, 1, 1, lk); held += lk;
    check(held == 3, "R7", "miss count cleared by good frame", held, 3);
    send_frame(1, 1, 0, lk);
    check(lk == 0, "R8", "lock dropped on fourth miss", lk, 0);
    report_marks("R8", 4);
  endtask

  task automatic t_relock();
    bit lk0, lk1, lk2;
    clear_stats();
    for (int k = 0; k < 100; k++) push(32'h5A00_0000 | 32'(k), -1, 1'b0);
    send_frame(0, 0, 0, lk0);
    send_frame(0, 0, 0, lk1);
    send_frame(0, 0, 1, lk2);
    check(lk0 == 0 && lk1 == 0 && lk2 == 1, "R10", "relock sequence",
          {lk0, lk1, lk2}, 1);
    check(fp_seen == 0, "R8", "no pulse while hunting", fp_seen, 0);
    clear_stats();
    send_frame(0, 1, 1, lk2);
    report_marks("R10", 1);
  endtask

  task automatic t_reset_locked();
    check(locked_o == 1'b1, "R11", "locked before reset", locked_o, 1);
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    check(locked_o == 1'b0 && frame_pulse_o == 1'b0 && payload_o == 1'b0 && data_o == '0,
          "R11", "outputs cleared by reset", {locked_o, frame_pulse_o, payload_o}, 0);
  endtask

  initial begin
    have_prev = 1'b0;
    clear_stats();
    t_reset_state();
    t_acquire();
    t_flywheel();
    t_loss();
    t_relock();
    t_reset_locked();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule